// File: doc/BRIEF.md
# Memory-Card Host Interrupt Status Register

This block gathers the interrupt events of a memory-card host controller into one 32-bit status word. Software reads and clears the word through a plain register port, which has an address, write data, a write enable and combinational read data. The event side takes single-cycle pulses when the data buffer has been filled with a block or emptied of one. It also takes a direction-specific DMA-mode flag for each of the two directions, a level-sensitive card interrupt line with its enable, an asynchronous out-of-band pin with its enable and polarity controls, and sixteen error-event pulses.

The buffer events become status flags when their direction runs under software control. When the direction runs under DMA, the same events become single-cycle DMA request pulses instead. The card interrupt bit is a live, gated view of the synchronized card line. The only way to remove it is to drop its enable. A summary bit shows whether any error flag is pending, so software can test one bit before it scans the error half of the word.

Top module: `mcard_irq_status`

## Requirements
- R1: While reset is asserted, and after it is released, every status bit reads 0 and both DMA request outputs are 0.
- R2: Bit 15 reads as the OR of bits 31:16. Writing to bit 15 changes nothing.
- R3: A pulse on `err_evt[k]` sets status bit 16+k on the next clock edge. The bit stays set until software clears it.
- R4: Bits 31:16, 9, 5 and 4 are write-one-to-clear. A write of 1 to such a bit clears it, and a write of 0 leaves it as it was.
- R5: Bit 9 is set only while `oob_en` is 1, when the synchronized pin becomes active. The active level is high when `oob_pol` is 1 and low when it is 0. The bit becomes visible after the third rising edge that follows the pin change. A pin that simply stays active does not set the bit again once it has been cleared.
- R6: Bit 8 equals the card line, synchronized over two edges, ANDed with `card_irq_en`. Writes to bit 8 are ignored. Setting the enable while the line is still active shows the bit in the same cycle.
- R7: With `rx_dma_en` at 0, a `blk_filled` pulse sets bit 5 on the next edge.
- R8: With `tx_dma_en` at 0, a `blk_emptied` pulse sets bit 4 on the next edge.
- R9: With the direction's DMA flag at 1, the buffer event leaves bit 5 or bit 4 at 0. Instead, `rx_dma_req` or `tx_dma_req` is 1 for exactly the one cycle that follows the edge that sampled the event.
- R10: Bits 14:10, 7:6 and 3:0 always read 0, and writes to them have no effect.
- R11: When a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R12: The word is read and written only at address `STAT_ADDR` (default 0x30). Reads at any other address return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write enable |
| reg_rdata | output | 32 | Read data (combinational) |
| err_evt | input | 16 | Error event pulses |
| blk_filled | input | 1 | Pulse: one block has been written into the buffer (card read) |
| blk_emptied | input | 1 | Pulse: the buffer has room for one block (card write) |
| rx_dma_en | input | 1 | Receive direction uses DMA |
| tx_dma_en | input | 1 | Transmit direction uses DMA |
| card_irq_lvl | input | 1 | Asynchronous card interrupt level |
| card_irq_en | input | 1 | Card interrupt enable |
| oob_pin | input | 1 | Asynchronous out-of-band interrupt pin |
| oob_en | input | 1 | Out-of-band detection enable |
| oob_pol | input | 1 | Out-of-band active level (1 = high) |
| rx_dma_req | output | 1 | Receive DMA request pulse |
| tx_dma_req | output | 1 | Transmit DMA request pulse |

## Verification
Each result has a fixed latency, and every check is taken at the falling edge where that latency ends. Buffer, error and write-clear effects, and the DMA request pulses, appear one edge after the stimulus. The card bit follows its line two edges later, and the out-of-band bit follows the pin three edges later; the bench samples one falling edge before each of these points as well as at it, so an early arrival shows up as a failure. Changes in enable and address act on the read data within the same cycle, so those checks sample shortly after the input is driven, with no clock edge in between.

// File: rtl/mcard_irq_pkg.sv
package mcard_irq_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned ERR_LO   = 16;
  localparam int unsigned ERR_W    = 16;
  localparam int unsigned B_ERRSUM = 15;
  localparam int unsigned B_OOB    = 9;
  localparam int unsigned B_CARD   = 8;
  localparam int unsigned B_RDRDY  = 5;
  localparam int unsigned B_WRRDY  = 4;
  // bits that always read zero
  localparam logic [DW-1:0] ZERO_MASK = 32'h0000_7CCF;
  // flopped write-one-to-clear flags: errors, out-of-band, read ready, write ready
  localparam int unsigned FLAG_W = ERR_W + 3;
endpackage

// File: rtl/mcard_rst_sync.sv
module mcard_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] stg_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_r <= 2'b00;
    else        stg_r <= {stg_r[0], 1'b1};
  end

  assign rst_n_o = stg_r[1];
endmodule

// File: rtl/mcard_sync.sv
module mcard_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_r;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_r[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_r <= '0;
    else        chain_r <= chain_d;
  end

  assign q_o = chain_r[STAGES-1];

  initial begin
    assert_stages_min_R5: assert (STAGES >= 2);
  end
endmodule

// File: rtl/mcard_w1c_bank.sv
module mcard_w1c_bank #(
  parameter int unsigned W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic [W-1:0] en;

  // set has priority over clear
  always_comb begin
    en  = set_i | clr_i;
    q_d = set_i | (q_r & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (en[i]) q_r[i] <= q_d[i];
      end
    end
  end

  assign q_o = q_r;

  for (genvar g = 0; g < W; g++) begin : g_chk
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> q_o[g]);
    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !q_o[g]);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[g] && !set_i[g]) |=> $stable(q_o[g]));
  end
endmodule

// File: rtl/mcard_buf_steer.sv
module mcard_buf_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_filled,
  input  logic blk_emptied,
  input  logic rx_dma_en,
  input  logic tx_dma_en,
  output logic set_rdrdy,
  output logic set_wrrdy,
  output logic rx_req,
  output logic tx_req
);
  logic rx_req_d, tx_req_d;
  logic rx_req_r, tx_req_r;

  always_comb begin
    set_rdrdy = blk_filled  & ~rx_dma_en;
    set_wrrdy = blk_emptied & ~tx_dma_en;
    rx_req_d  = blk_filled  &  rx_dma_en;
    tx_req_d  = blk_emptied &  tx_dma_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_req_r <= 1'b0;
      tx_req_r <= 1'b0;
    end else begin
      rx_req_r <= rx_req_d;
      tx_req_r <= tx_req_d;
    end
  end

  assign rx_req = rx_req_r;
  assign tx_req = tx_req_r;

  assert_rx_req_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> $past(blk_filled && rx_dma_en));
  assert_tx_req_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(blk_emptied && tx_dma_en));
endmodule

// File: rtl/mcard_oob_detect.sv
module mcard_oob_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic pol,
  input  logic en,
  output logic set_o
);
  logic act;
  logic act_r;

  always_comb act = pol ? pin_s : ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_r <= 1'b0;
    else        act_r <= act;
  end

  always_comb set_o = en & act & ~act_r;
endmodule

// File: rtl/mcard_irq_status.sv
module mcard_irq_status
  import mcard_irq_pkg::*;
#(
  parameter int unsigned         ADDR_W      = 8,
  parameter logic [ADDR_W-1:0]   STAT_ADDR   = 8'h30,
  parameter int unsigned         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_we,
  output logic [DW-1:0]     reg_rdata,
  input  logic [ERR_W-1:0]  err_evt,
  input  logic              blk_filled,
  input  logic              blk_emptied,
  input  logic              rx_dma_en,
  input  logic              tx_dma_en,
  input  logic              card_irq_lvl,
  input  logic              card_irq_en,
  input  logic              oob_pin,
  input  logic              oob_en,
  input  logic              oob_pol,
  output logic              rx_dma_req,
  output logic              tx_dma_req
);
  logic              rst_ns;
  logic              card_s, oob_s;
  logic              oob_set, set_rd, set_wr;
  logic              wr_hit;
  logic [FLAG_W-1:0] flag_set, flag_clr, flag_q;
  logic [ERR_W-1:0]  err_q;
  logic              oob_q, rd_q, wr_q, card_bit;
  logic [DW-1:0]     status;
  logic              unused_wbits;

  mcard_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_ns)
  );

  mcard_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_ns),
    .d_i   ({card_irq_lvl, oob_pin}),
    .q_o   ({card_s, oob_s})
  );

  mcard_oob_detect u_oob (
    .clk   (clk),
    .rst_n (rst_ns),
    .pin_s (oob_s),
    .pol   (oob_pol),
    .en    (oob_en),
    .set_o (oob_set)
  );

  mcard_buf_steer u_buf (
    .clk         (clk),
    .rst_n       (rst_ns),
    .blk_filled  (blk_filled),
    .blk_emptied (blk_emptied),
    .rx_dma_en   (rx_dma_en),
    .tx_dma_en   (tx_dma_en),
    .set_rdrdy   (set_rd),
    .set_wrrdy   (set_wr),
    .rx_req      (rx_dma_req),
    .tx_req      (tx_dma_req)
  );

  always_comb begin
    wr_hit   = reg_we && (reg_addr == STAT_ADDR);
    flag_set = {err_evt, oob_set, set_rd, set_wr};
    flag_clr = wr_hit ? {reg_wdata[ERR_LO +: ERR_W], reg_wdata[B_OOB],
                         reg_wdata[B_RDRDY], reg_wdata[B_WRRDY]}
                      : '0;
  end

  mcard_w1c_bank #(.W(FLAG_W)) u_flags (
    .clk   (clk),
    .rst_n (rst_ns),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flag_q)
  );

  always_comb begin
    {err_q, oob_q, rd_q, wr_q} = flag_q;
    card_bit = card_s & card_irq_en;
    status   = '0;
    status[ERR_LO +: ERR_W] = err_q;
    status[B_ERRSUM]        = |err_q;
    status[B_OOB]           = oob_q;
    status[B_CARD]          = card_bit;
    status[B_RDRDY]         = rd_q;
    status[B_WRRDY]         = wr_q;
    reg_rdata = (reg_addr == STAT_ADDR) ? status : '0;
  end

  assign unused_wbits = ^{reg_wdata[15:10], reg_wdata[8:6], reg_wdata[3:0]};

  assert_zero_bits_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_rdata & ZERO_MASK) == '0);
  assert_card_gated_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    !card_irq_en |-> !reg_rdata[B_CARD]);
  assert_oob_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(oob_q) |-> $past(oob_en));
  assert_no_rdrdy_in_dma_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(rx_dma_en) |-> !$rose(rd_q));
  assert_no_wrrdy_in_dma_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(tx_dma_en) |-> !$rose(wr_q));
  assert_other_addr_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_addr != STAT_ADDR) |-> (reg_rdata == '0));
endmodule

// File: tb/mcard_irq_status_bench.sv
module mcard_irq_status_bench;
  localparam logic [7:0] STAT = 8'h30;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic [31:0] reg_rdata;
  logic [15:0] err_evt;
  logic        blk_filled, blk_emptied, rx_dma_en, tx_dma_en;
  logic        card_irq_lvl, card_irq_en, oob_pin, oob_en, oob_pol;
  logic        rx_dma_req, tx_dma_req;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcard_irq_status u_mcard_irq_status (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .err_evt(err_evt),
    .blk_filled(blk_filled), .blk_emptied(blk_emptied),
    .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
    .card_irq_lvl(card_irq_lvl), .card_irq_en(card_irq_en),
    .oob_pin(oob_pin), .oob_en(oob_en), .oob_pol(oob_pol),
    .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(output logic [31:0] v);
    reg_addr = STAT;
    #1 v = reg_rdata;
  endtask

  task automatic wr(logic [31:0] d);
    reg_addr = STAT; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst_n = 1'b0;
    tick(3);
    rd(v);
    chk("R1 in reset", v, 32'h0);
    rst_n = 1'b1;
    tick(4);
    rd(v);
    chk("R1 after reset", v, 32'h0);
    chk("R1 dma reqs", {30'h0, rx_dma_req, tx_dma_req}, 32'h0);
  endtask

  task automatic t_errors();
    logic [31:0] v;
    err_evt = 16'h0008; @(negedge clk); err_evt = '0;
    rd(v); chk("R3 err bit 19 and R2 summary", v, 32'h0008_8000);
    wr(32'h0000_8000);
    rd(v); chk("R2 summary write ignored", v, 32'h0008_8000);
    wr(32'h0008_0000);
    rd(v); chk("R4 err clear and R2 summary drop", v, 32'h0);
    err_evt = 16'h8001; @(negedge clk); err_evt = '0;
    wr(32'h8000_0000);
    rd(v); chk("R4 partial err clear", v, 32'h0001_8000);
    wr(32'h0001_0000);
    rd(v); chk("R4 err clear rest", v, 32'h0);
  endtask

  task automatic t_buffer();
    logic [31:0] v;
    blk_filled = 1'b1; @(negedge clk); blk_filled = 1'b0;
    rd(v); chk("R7 read ready set", v, 32'h0000_0020);
    wr(32'h0);
    rd(v); chk("R4 write 0 keeps", v, 32'h0000_0020);
    wr(32'h0000_0020);
    rd(v); chk("R4 read ready clear", v, 32'h0);
    blk_emptied = 1'b1; @(negedge clk); blk_emptied = 1'b0;
    rd(v); chk("R8 write ready set", v, 32'h0000_0010);
    wr(32'h0000_0010);
    rd(v); chk("R4 write ready clear", v, 32'h0);
  endtask

  task automatic t_dma();
    logic [31:0] v;
    rx_dma_en = 1'b1;
    blk_filled = 1'b1; @(negedge clk); blk_filled = 1'b0;
    chk("R9 rx req pulse", {31'h0, rx_dma_req}, 32'h1);
    rd(v); chk("R9 read ready stays 0", v, 32'h0);
    @(negedge clk);
    chk("R9 rx req one cycle", {31'h0, rx_dma_req}, 32'h0);
    rx_dma_en = 1'b0;
    tx_dma_en = 1'b1;
    blk_emptied = 1'b1; @(negedge clk); blk_emptied = 1'b0;
    chk("R9 tx req pulse", {31'h0, tx_dma_req}, 32'h1);
    rd(v); chk("R9 write ready stays 0", v, 32'h0);
    @(negedge clk);
    chk("R9 tx req one cycle", {31'h0, tx_dma_req}, 32'h0);
    tx_dma_en = 1'b0;
  endtask

  task automatic t_priority();
    logic [31:0] v;
    blk_filled = 1'b1; @(negedge clk); blk_filled = 1'b0;
    reg_addr = STAT; reg_wdata = 32'h0000_0020; reg_we = 1'b1; blk_filled = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; blk_filled = 1'b0;
    rd(v); chk("R11 set beats clear", v, 32'h0000_0020);
    wr(32'h0000_0020);
    rd(v); chk("R11 later clear", v, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(32'hFFFF_FFFF);
    rd(v); chk("R10 write all ones from zero", v, 32'h0);
    err_evt = 16'hFFFF; blk_filled = 1'b1; blk_emptied = 1'b1;
    @(negedge clk);
    err_evt = '0; blk_filled = 1'b0; blk_emptied = 1'b0;
    rd(v); chk("R10 zero bits with all flags set", v, 32'hFFFF_8030);
    wr(32'hFFFF_FFFF);
    rd(v); chk("R4 clear all", v, 32'h0);
  endtask

  task automatic t_card();
    logic [31:0] v;
    card_irq_en = 1'b0; card_irq_lvl = 1'b1;
    tick(3);
    rd(v); chk("R6 masked by enable", v, 32'h0);
    card_irq_en = 1'b1;
    rd(v); chk("R6 re-enable asserts at once", v, 32'h0000_0100);
    wr(32'h0000_0100);
    rd(v); chk("R6 write ignored", v, 32'h0000_0100);
    card_irq_en = 1'b0;
    rd(v); chk("R6 enable drop removes", v, 32'h0);
    card_irq_en = 1'b1; card_irq_lvl = 1'b0;
    @(negedge clk);
    rd(v); chk("R6 sync latency one edge", v, 32'h0000_0100);
    @(negedge clk);
    rd(v); chk("R6 line released", v, 32'h0);
    card_irq_en = 1'b0;
  endtask

  task automatic t_oob();
    logic [31:0] v;
    oob_pol = 1'b1; oob_en = 1'b0; oob_pin = 1'b1;
    tick(4);
    rd(v); chk("R5 disabled no set", v, 32'h0);
    oob_pin = 1'b0; tick(4);
    oob_en = 1'b1; oob_pin = 1'b1;
    tick(2);
    rd(v); chk("R5 not before third edge", v, 32'h0);
    @(negedge clk);
    rd(v); chk("R5 active high sets", v, 32'h0000_0200);
    wr(32'h0000_0200);
    tick(3);
    rd(v); chk("R5 held level no reset", v, 32'h0);
    oob_pol = 1'b0;
    tick(2);
    rd(v); chk("R5 polarity swap away from active", v, 32'h0);
    oob_pin = 1'b0;
    tick(3);
    rd(v); chk("R5 active low sets", v, 32'h0000_0200);
    oob_en = 1'b0;
    wr(32'h0000_0200);
    rd(v); chk("R4 oob clear", v, 32'h0);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    blk_filled = 1'b1; @(negedge clk); blk_filled = 1'b0;
    reg_addr = 8'h34;
    #1 chk("R12 other address reads 0", reg_rdata, 32'h0);
    reg_wdata = 32'h0000_0020; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    rd(v); chk("R12 other address write ignored", v, 32'h0000_0020);
    wr(32'h0000_0020);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = STAT; reg_wdata = '0; reg_we = 1'b0;
    err_evt = '0; blk_filled = 1'b0; blk_emptied = 1'b0;
    rx_dma_en = 1'b0; tx_dma_en = 1'b0;
    card_irq_lvl = 1'b0; card_irq_en = 1'b0;
    oob_pin = 1'b0; oob_en = 1'b0; oob_pol = 1'b1;
    @(negedge clk);
    t_reset();
    t_errors();
    t_buffer();
    t_dma();
    t_priority();
    t_reserved();
    t_card();
    t_oob();
    t_addr();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule